// File: doc/BRIEF.md
# Multi-Channel Repeating Interval Timer

This block holds a set of independent down-counting channels behind a simple register bus. All channels share one interrupt output. A channel starts when software writes a nonzero interval to it, and there is no separate start bit. From then on it counts down once per clock. When the count reaches zero the channel raises its pending flag and reloads the interval, so it repeats every interval + 1 cycles until software stops it.

Bit 31 of an interval write is the load bit. With the load bit set, the channel takes the new interval at once and restarts its count. The same write with an interval of zero halts the channel. Without the load bit, a running channel keeps counting, and the new interval is used at the next reload. Software services the interrupt by reading the global flag word and clearing each flagged channel with a write-one-to-clear to its status word.

Each channel is a two-state machine with states IDLE and RUN. It has five named transitions:
- START: IDLE to RUN on a nonzero interval write.
- RESTART: RUN to RUN on a load write with a nonzero value.
- FORCE_STOP: RUN to IDLE on a load write with a zero value.
- WRAP: RUN to RUN when the count expires and the next interval is nonzero.
- EXPIRE: RUN to IDLE when the count expires and the next interval is zero.

Top module: `rpt_interval_timer`

## Requirements
- R1: In IDLE, a write of a nonzero value to the interval word (channel base + 0x0, value in bits [CNT_W-1:0]) enters RUN. The count word (+0x4) then reads that value, and the status word (+0xC) reads run in bit 1.
- R2: In RUN, the count drops by one on every clock. In the cycle after the count reads 0, the pending flag (status bit 0) sets and the count reloads, giving a period of interval + 1 clocks that repeats.
- R3: An interval write with bit 31 set and a nonzero value, made to a running channel, replaces the count with the new value at once.
- R4: An interval write with bit 31 set and value 0 puts the channel in IDLE with count 0. No pending flag appears afterwards.
- R5: An interval write without bit 31, made to a running channel, leaves the count decrementing as before. The interval word reads back the new value, and the next reload uses it.
- R6: Writing 1 to status bit 0 clears the pending flag. Writing 0 there leaves it set.
- R7: The global flag word, at address NUM_CH*16, shows channel i's pending flag in bit i.
- R8: The configuration word, at address NUM_CH*16 + 4, reads the channel count in its low byte.
- R9: The interval field holds CNT_W bits, so the largest interval is 2^CNT_W - 1. Write bits above the field are dropped, except for bit 31.
- R10: The interrupt output is high exactly when some channel has both its pending flag and its enable bit (control word + 0x8, bit 0) set.
- R11: A zero interval written without bit 31 leaves an idle channel in IDLE. A running channel finishes its current count, sets pending and then enters IDLE.
- R12: After reset, every channel is in IDLE with count, interval, enable and pending all 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address of the word written or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two cases are the hardest to reach from the ports. The first is a change of interval without the load bit while a channel is mid-count. The second is the EXPIRE transition, where a zero interval is written without the load bit and the channel only stops at its next reload. The stimulus schedules each bus write on a known clock edge and counts the cycles down to expiry. It then reads the count one cycle before and one cycle after the reload, so that each check shows whether the old or the new interval was taken. The pending-clear checks are placed so that no expiry falls on the same edge as the clear.

// File: rtl/rit_pkg.sv
package rit_pkg;
    typedef enum logic {CH_IDLE, CH_RUN} ch_state_e;

    // word index inside a channel's 16-byte window
    localparam logic [1:0] W_IVL = 2'd0;
    localparam logic [1:0] W_CNT = 2'd1;
    localparam logic [1:0] W_CTL = 2'd2;
    localparam logic [1:0] W_STA = 2'd3;

    // word index inside the module window after the channels
    localparam logic [1:0] W_GFLAG = 2'd0;
    localparam logic [1:0] W_CFG   = 2'd1;

    localparam int LOAD_BIT = 31;
    localparam int STA_PEND = 0;
    localparam int STA_RUN  = 1;
endpackage

// File: rtl/rit_channel.sv
module rit_channel
    import rit_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_we,
    input  logic             ivl_load,
    input  logic [CNT_W-1:0] ivl_wdata,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic             pend_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ivl_o,
    output logic             en_o,
    output logic             pend_o,
    output logic             run_o
);
    ch_state_e        state, nxt_state;
    logic [CNT_W-1:0] cnt, ivl;
    logic             en, pend;

    logic             hard_load;  // load-bit write
    logic [CNT_W-1:0] next_ivl;   // interval used at the coming reload
    logic             expire;     // count wraps this cycle

    assign hard_load = ivl_we && ivl_load;
    assign next_ivl  = ivl_we ? ivl_wdata : ivl;
    assign expire    = (state == CH_RUN) && !hard_load && (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= nxt_state;
    end

    // transitions: START, RESTART, FORCE_STOP, WRAP, EXPIRE
    always_comb begin
        nxt_state = state;
        unique case (state)
            CH_IDLE: if (ivl_we && ivl_wdata != '0) nxt_state = CH_RUN;   // START
            CH_RUN: begin
                if (hard_load && ivl_wdata == '0)   nxt_state = CH_IDLE;  // FORCE_STOP
                else if (expire && next_ivl == '0)  nxt_state = CH_IDLE;  // EXPIRE
            end
            default: nxt_state = CH_IDLE;
        endcase
    end

    // datapath / outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            ivl  <= '0;
            en   <= 1'b0;
            pend <= 1'b0;
        end else begin
            ivl <= next_ivl;
            if (ctl_we) en <= ctl_en;
            if (expire)        pend <= 1'b1;
            else if (pend_clr) pend <= 1'b0;
            unique case (state)
                CH_IDLE: cnt <= ivl_we ? ivl_wdata : '0;
                CH_RUN: begin
                    if (hard_load)        cnt <= ivl_wdata;   // RESTART / FORCE_STOP
                    else if (cnt == '0)   cnt <= next_ivl;    // WRAP / EXPIRE
                    else                  cnt <= cnt - 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign cnt_o  = cnt;
    assign ivl_o  = ivl;
    assign en_o   = en;
    assign pend_o = pend;
    assign run_o  = (state == CH_RUN);
endmodule

// File: rtl/rit_bus_decode.sv
module rit_bus_decode
    import rit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CNT_W-1:0]  cnt_i [NUM_CH],
    input  logic [CNT_W-1:0]  ivl_i [NUM_CH],
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] pend_i,
    input  logic [NUM_CH-1:0] run_i,
    output logic [NUM_CH-1:0] ivl_we,
    output logic [NUM_CH-1:0] ctl_we,
    output logic [NUM_CH-1:0] pend_clr,
    output logic [31:0]       bus_rdata
);
    localparam int IDX_W = ADDR_W - 4;
    localparam int PAD_W = 32 - CNT_W;

    logic [IDX_W-1:0] idx;
    logic [1:0]       word;

    assign idx  = bus_addr[ADDR_W-1:4];
    assign word = bus_addr[3:2];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
        logic hit;
        assign hit         = bus_wr && (idx == IDX_W'(i));
        assign ivl_we[i]   = hit && (word == W_IVL);
        assign ctl_we[i]   = hit && (word == W_CTL);
        assign pend_clr[i] = hit && (word == W_STA) && bus_wdata[STA_PEND];
    end

    always_comb begin
        bus_rdata = '0;
        if (idx == IDX_W'(NUM_CH)) begin
            if (word == W_GFLAG)    bus_rdata = 32'(pend_i);
            else if (word == W_CFG) bus_rdata = 32'(NUM_CH);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (idx == IDX_W'(i)) begin
                    unique case (word)
                        W_IVL: bus_rdata = {{PAD_W{1'b0}}, ivl_i[i]};
                        W_CNT: bus_rdata = {{PAD_W{1'b0}}, cnt_i[i]};
                        W_CTL: bus_rdata = 32'(en_i[i]);
                        W_STA: bus_rdata = 32'({run_i[i], pend_i[i]});
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/rpt_interval_timer.sv
module rpt_interval_timer
    import rit_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);
    logic [CNT_W-1:0]  cnt_v [NUM_CH];
    logic [CNT_W-1:0]  ivl_v [NUM_CH];
    logic [NUM_CH-1:0] en_v, pend_v, run_v;
    logic [NUM_CH-1:0] ivl_we, ctl_we, pend_clr;

    rit_bus_decode #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt_v),
        .ivl_i     (ivl_v),
        .en_i      (en_v),
        .pend_i    (pend_v),
        .run_i     (run_v),
        .ivl_we    (ivl_we),
        .ctl_we    (ctl_we),
        .pend_clr  (pend_clr),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        rit_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ivl_we    (ivl_we[i]),
            .ivl_load  (bus_wdata[LOAD_BIT]),
            .ivl_wdata (bus_wdata[CNT_W-1:0]),
            .ctl_we    (ctl_we[i]),
            .ctl_en    (bus_wdata[0]),
            .pend_clr  (pend_clr[i]),
            .cnt_o     (cnt_v[i]),
            .ivl_o     (ivl_v[i]),
            .en_o      (en_v[i]),
            .pend_o    (pend_v[i]),
            .run_o     (run_v[i])
        );
    end

    assign irq_out = |(pend_v & en_v);
endmodule

// File: rtl/rit_checker.sv
module rit_checker #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pend_v,
    input logic [NUM_CH-1:0] run_v
);
    localparam int IDX_W = ADDR_W - 4;

    // R7: the read path returns the channels' pending flags
    a_r7_gflag_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(NUM_CH * 16)) |-> (bus_rdata == 32'(pend_v)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic ivl_hit, sta_hit;
        assign ivl_hit = bus_wr && bus_addr[ADDR_W-1:4] == IDX_W'(i) && bus_addr[3:2] == 2'd0;
        assign sta_hit = bus_wr && bus_addr[ADDR_W-1:4] == IDX_W'(i) && bus_addr[3:2] == 2'd3;

        a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
            (ivl_hit && !run_v[i] && bus_wdata[23:0] != 24'd0) |=> run_v[i]);

        a_r4_force_stop: assert property (@(posedge clk) disable iff (!rst_n)
            (ivl_hit && bus_wdata[31] && bus_wdata[23:0] == 24'd0) |=> !run_v[i]);

        a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (sta_hit && !bus_wdata[0] && pend_v[i]) |=> pend_v[i]);

        a_r2_pend_from_run: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_v[i]) |-> $past(run_v[i]));
    end
endmodule

bind rpt_interval_timer rit_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rit_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_v    (pend_v),
    .run_v     (run_v)
);

// File: tb/test_rpt_interval_timer.sv
`timescale 1ns/100ps
module test_rpt_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    rpt_interval_timer i_rpt_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // monitor: pops expectations and compares against the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? 32'(irq_out) : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #2;
        bus_wr    = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #0.1;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->sample_ev;
        #0.1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1; it.exp = 32'(e); it.tag = tag;
        sb_q.push_back(it);
        ->sample_ev;
        #0.1;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state
        chk(8'h0C, 32'h0, "R12 status ch0");
        chk(8'h04, 32'h0, "R12 count ch0");
        chk(8'h00, 32'h0, "R12 interval ch0");
        chk(8'h08, 32'h0, "R12 enable ch0");
        chk_irq(1'b0, "R12 irq");
        chk(8'h40, 32'h0, "R12 gflag");
        chk(8'h44, 32'd4, "R8 config channel count");

        // R1 start, R2 period
        wr(8'h00, 32'd5);
        chk(8'h04, 32'd5, "R1 count loaded");
        chk(8'h0C, 32'h2, "R1 running");
        tick(1);
        chk(8'h04, 32'd4, "R2 decrement");
        tick(4);
        chk(8'h0C, 32'h2, "R2 no pend at zero");
        tick(1);
        chk(8'h0C, 32'h3, "R2 pend after interval+1");
        chk(8'h04, 32'd5, "R2 reload");
        chk(8'h40, 32'h1, "R7 gflag ch0");
        chk_irq(1'b0, "R10 masked");
        wr(8'h08, 32'h1);
        chk_irq(1'b1, "R10 enabled");
        wr(8'h0C, 32'h0);
        chk(8'h0C, 32'h3, "R6 write zero keeps pend");
        wr(8'h0C, 32'h1);
        chk(8'h0C, 32'h2, "R6 w1c clears");
        chk_irq(1'b0, "R10 cleared");
        tick(2);
        chk(8'h0C, 32'h2, "R2 second period not yet");
        tick(1);
        chk(8'h0C, 32'h3, "R2 second period pend");

        // R5 change without load
        wr(8'h00, 32'd3);
        chk(8'h04, 32'd4, "R5 count kept");
        chk(8'h00, 32'd3, "R5 interval readback");
        tick(4);
        chk(8'h04, 32'd0, "R5 old count to zero");
        tick(1);
        chk(8'h04, 32'd3, "R5 new interval reload");

        // R3 load restart
        wr(8'h00, 32'h8000_0009);
        chk(8'h04, 32'd9, "R3 immediate restart");
        tick(1);
        chk(8'h04, 32'd8, "R3 counting from new");
        wr(8'h0C, 32'h1);

        // R4 forced stop
        wr(8'h00, 32'h8000_0000);
        chk(8'h0C, 32'h0, "R4 stopped");
        chk(8'h04, 32'h0, "R4 count cleared");
        tick(20);
        chk(8'h0C, 32'h0, "R4 no later pend");
        chk(8'h04, 32'h0, "R4 count stays zero");

        // R11 zero interval without load
        wr(8'h00, 32'h0);
        chk(8'h0C, 32'h0, "R11 idle stays idle");
        wr(8'h10, 32'd2);
        wr(8'h10, 32'd0);
        chk(8'h14, 32'd1, "R11 running keeps counting");
        tick(1);
        chk(8'h1C, 32'h2, "R11 still running at zero");
        tick(1);
        chk(8'h1C, 32'h1, "R11 pend then idle");
        chk(8'h14, 32'h0, "R11 count zero");
        chk(8'h40, 32'h2, "R7 gflag ch1");
        wr(8'h18, 32'h1);
        chk_irq(1'b1, "R10 ch1 enabled");

        // R9 max interval
        wr(8'h30, 32'h7FFF_FFFF);
        chk(8'h34, 32'h00FF_FFFF, "R9 count max");
        chk(8'h30, 32'h00FF_FFFF, "R9 interval max");
        chk(8'h3C, 32'h2, "R9 running");

        // R7 multiple channels
        wr(8'h20, 32'd1);
        tick(2);
        chk(8'h40, 32'h6, "R7 gflag ch1+ch2");
        wr(8'h1C, 32'h1);
        chk(8'h40, 32'h4, "R7 gflag ch2 only");
        chk_irq(1'b0, "R10 ch2 not enabled");
        chk(8'h44, 32'd4, "R8 config again");

        tick(1);
        done = 1;
        summary();
        $finish;
    end
endmodule